// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This unit performs a 32 x 32 multiply, with an optional 64-bit accumulate, for a processor datapath. It is built to use little area: a multiplier operand is consumed two bits per clock through radix-4 Booth digits. The running total is kept in carry-save form in two 64-bit registers. One carry-propagate addition at the end turns the pair back into a binary result. The same engine serves the short forms (32-bit product, 32-bit product plus addend) and the long forms (64-bit signed or unsigned product, with or without a 64-bit addend).

The host drives two 32-bit buses. For an accumulating operation it first strobes the addend in, with the high word on bus A and the low word on bus B. In the next cycle it strobes the operands in, with the multiplier on bus A and the multiplicand on bus B, and waits for the ready flag. It then reads the 64-bit result one 32-bit half at a time through a half-select input. Finally it strobes a clear, which zeroes the internal state and returns the unit to idle. A plain multiply skips the addend strobe and relies on the state already being cleared.

Top module: `mac32_iter`

## Requirements
- R1: While reset is asserted, and after it is released: ready is 0, the result port reads 0 for both halves, and clkEn is held at 1.
- R2: A loadOps pulse in idle captures busA as the multiplier and busB as the multiplicand. Ready rises 18 clock edges after the capturing edge: 17 Booth steps plus one resolve cycle.
- R3: With unsignedMode = 1 at the operand load, both operands are zero-extended. The 64-bit result is (A*B + accumulator) modulo 2^64, which includes wrap-around past all ones.
- R4: With unsignedMode = 0, both operands are taken as two's complement. The 64-bit result is the signed product plus the accumulator, modulo 2^64. This holds for the corner operands 0x80000000, 0x7FFFFFFF, 0xFFFFFFFF and 1.
- R5: A loadAcc pulse in idle sets the accumulator to {busA, busB}, with busA in bits 63:32. The value can be read back at once, and its low word alone gives the 32-bit multiply-accumulate result.
- R6: readHigh = 0 puts result bits 31:0 on the result port, and readHigh = 1 puts bits 63:32 there. It may be changed at any time while ready is high.
- R7: Ready stays high until clearState is asserted. The cycle after clearState is sampled with ready high, ready is 0 and both result halves read 0.
- R8: loadOps and loadAcc are ignored while an operation runs and while ready is high. The result and ready are unchanged.
- R9: After a clear, an operation started without loadAcc accumulates zero, so it returns the bare product.
- R10: If loadOps and loadAcc are asserted in the same idle cycle, the operand load takes effect and the accumulator keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | output | 1 | Clock enable to the surrounding pipeline, always 1 |
| busA | input | 32 | Multiplier operand, or accumulator high word |
| busB | input | 32 | Multiplicand operand, or accumulator low word |
| loadOps | input | 1 | Capture operands and start |
| loadAcc | input | 1 | Preload accumulator with {busA, busB} |
| clearState | input | 1 | Zero partial sum and carry, return to idle |
| unsignedMode | input | 1 | 1 = unsigned, 0 = signed; sampled with loadOps |
| readHigh | input | 1 | 0 = result bits 31:0, 1 = bits 63:32 |
| ready | output | 1 | Result complete |
| result | output | 32 | Selected half of the 64-bit result |

## Verification
The assertions assume the host follows the handshake. Loads are issued only while idle, and a clear is issued only once ready is high, so a preload is never overlapped by an operation and no strobe is held longer than one cycle, except where a test means to show that it is ignored. The stimulus drives every strobe for exactly one cycle from the falling edge and waits for ready before it reads or clears. Deliberate out-of-turn loads during a run and during the ready window are the only departures. Random operand pairs are mixed with the signed and unsigned corner operands and with a wrap-around accumulate.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic accLoad;
    logic opsLoad;
    logic step;
    logic resolve;
    logic clear;
  } macStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_RESOLVE = 2'd2,
    ST_DONE    = 2'd3
  } macState_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int STEPS = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadOps,
  input  logic        loadAcc,
  input  logic        clearState,
  output macStrobes_t strobes,
  output logic        ready
);

  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  macState_t state, nextState;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (loadOps) begin
          strobes.opsLoad = 1'b1;
          nextState       = ST_RUN;
        end else if (loadAcc) begin
          strobes.accLoad = 1'b1;
        end else if (clearState) begin
          strobes.clear = 1'b1;
        end
      end
      ST_RUN: begin
        strobes.step = 1'b1;
        if (stepCnt == LAST_STEP) nextState = ST_RESOLVE;
      end
      ST_RESOLVE: begin
        strobes.resolve = 1'b1;
        nextState       = ST_DONE;
      end
      ST_DONE: begin
        if (clearState) begin
          strobes.clear = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= nextState;
      if (strobes.opsLoad)   stepCnt <= '0;
      else if (strobes.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign ready = (state == ST_DONE);

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !clearState) |=> ready); // R7
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (ready && clearState) |=> !ready); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.opsLoad |=> !ready); // R2
  AST_IGNORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ready && (loadOps || loadAcc) && !clearState) |=> ready); // R8

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  macStrobes_t      strobes,
  input  logic [WIDTH-1:0] busA,
  input  logic [WIDTH-1:0] busB,
  input  logic             unsignedMode,
  input  logic             readHigh,
  output logic [WIDTH-1:0] result
);

  localparam int PW = 2 * WIDTH;
  localparam int MW = WIDTH + 2;

  logic [MW-1:0] mplr;
  logic          prevBit;
  logic [PW-1:0] mcand;
  logic [PW-1:0] psum;
  logic [PW-1:0] pcarry;

  logic [2:0]    triplet;
  logic          digOne, digTwo, digNeg;
  logic [PW-1:0] mag, partProd, sumNext, majNext, carryNext;
  logic          extA, extB;

  always_comb begin
    triplet = {mplr[1:0], prevBit};
    digOne  = 1'b0;
    digTwo  = 1'b0;
    digNeg  = 1'b0;
    unique case (triplet)
      3'b001, 3'b010: digOne = 1'b1;
      3'b011:         digTwo = 1'b1;
      3'b100:         begin digTwo = 1'b1; digNeg = 1'b1; end
      3'b101, 3'b110: begin digOne = 1'b1; digNeg = 1'b1; end
      default:        ;
    endcase
    if (digOne)      mag = mcand;
    else if (digTwo) mag = {mcand[PW-2:0], 1'b0};
    else             mag = '0;
    partProd  = digNeg ? ~mag : mag;
    sumNext   = psum ^ pcarry ^ partProd;
    majNext   = (psum & pcarry) | (psum & partProd) | (pcarry & partProd);
    carryNext = {majNext[PW-2:0], digNeg};
  end

  assign extA = ~unsignedMode & busA[WIDTH-1];
  assign extB = ~unsignedMode & busB[WIDTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mplr    <= '0;
      prevBit <= 1'b0;
      mcand   <= '0;
      psum    <= '0;
      pcarry  <= '0;
    end else begin
      if (strobes.accLoad) begin
        psum   <= {busA, busB};
        pcarry <= '0;
      end
      if (strobes.opsLoad) begin
        mplr    <= {{2{extA}}, busA};
        prevBit <= 1'b0;
        mcand   <= {{WIDTH{extB}}, busB};
      end
      if (strobes.step) begin
        psum    <= sumNext;
        pcarry  <= carryNext;
        prevBit <= mplr[1];
        mplr    <= {2'b00, mplr[MW-1:2]};
        mcand   <= {mcand[PW-3:0], 2'b00};
      end
      if (strobes.resolve) begin
        psum   <= psum + pcarry;
        pcarry <= '0;
      end
      if (strobes.clear) begin
        psum   <= '0;
        pcarry <= '0;
      end
    end
  end

  assign result = readHigh ? psum[PW-1:WIDTH] : psum[WIDTH-1:0];

  AST_CARRY_RESOLVED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resolve |=> (pcarry == '0)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (psum == '0 && pcarry == '0)); // R7
  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accLoad |=> (psum == $past({busA, busB}))); // R5

endmodule

// File: rtl/mac32_iter.sv
module mac32_iter
  import mac_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  output logic             clkEn,
  input  logic [WIDTH-1:0] busA,
  input  logic [WIDTH-1:0] busB,
  input  logic             loadOps,
  input  logic             loadAcc,
  input  logic             clearState,
  input  logic             unsignedMode,
  input  logic             readHigh,
  output logic             ready,
  output logic [WIDTH-1:0] result
);

  localparam int STEPS = WIDTH / 2 + 1;

  macStrobes_t strobes;

  assign clkEn = 1'b1;

  mac_ctrl #(.STEPS(STEPS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadOps    (loadOps),
    .loadAcc    (loadAcc),
    .clearState (clearState),
    .strobes    (strobes),
    .ready      (ready)
  );

  mac_datapath #(.WIDTH(WIDTH)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busA         (busA),
    .busB         (busB),
    .unsignedMode (unsignedMode),
    .readHigh     (readHigh),
    .result       (result)
  );

endmodule

// File: tb/sim_mac32_iter.sv
module sim_mac32_iter;

  localparam int PERIOD  = 10;
  localparam int EXP_LAT = 19;
  localparam int SEED    = 1234;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn, ready;
  logic [31:0] busA = '0, busB = '0, result;
  logic loadOps = 0, loadAcc = 0, clearState = 0, unsignedMode = 0, readHigh = 0;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD / 2) clk = ~clk;

  mac32_iter u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .busA(busA), .busB(busB),
    .loadOps(loadOps), .loadAcc(loadAcc), .clearState(clearState),
    .unsignedMode(unsignedMode), .readHigh(readHigh), .ready(ready), .result(result)
  );

  function automatic logic [63:0] refMac(input logic uns, input logic [31:0] a,
                                         input logic [31:0] b, input logic [63:0] acc);
    logic [63:0] ea, eb;
    ea = uns ? {32'b0, a} : {{32{a[31]}}, a};
    eb = uns ? {32'b0, b} : {{32{b[31]}}, b};
    return ea * eb + acc;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readBoth(output logic [63:0] v);
    readHigh = 1'b0; #1; v[31:0]  = result;
    readHigh = 1'b1; #1; v[63:32] = result;
    readHigh = 1'b0; #1;
  endtask

  task automatic preload(input logic [63:0] acc);
    logic [63:0] v;
    busA = acc[63:32]; busB = acc[31:0]; loadAcc = 1'b1;
    @(negedge clk); loadAcc = 1'b0;
    readBoth(v);
    chk("R5 preload readback", v, acc);
  endtask

  task automatic startWait(input logic uns, input logic [31:0] a, input logic [31:0] b);
    int lat;
    unsignedMode = uns; busA = a; busB = b; loadOps = 1'b1;
    @(negedge clk); loadOps = 1'b0;
    lat = 1;
    while (!ready && lat < 100) begin @(negedge clk); lat++; end
    chk("R2 latency", 64'(lat), 64'(EXP_LAT));
  endtask

  task automatic clearUnit();
    logic [63:0] v;
    clearState = 1'b1;
    @(negedge clk); clearState = 1'b0;
    chk("R7 ready low after clear", {63'b0, ready}, 64'd0);
    readBoth(v);
    chk("R7 result zero after clear", v, 64'd0);
  endtask

  task automatic runOp(input string tag, input logic uns, input logic doPre,
                       input logic [63:0] acc, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] v;
    if (doPre) preload(acc);
    startWait(uns, a, b);
    readBoth(v);
    chk(tag, v, refMac(uns, a, b, doPre ? acc : 64'd0));
    clearUnit();
  endtask

  initial begin
    #(PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] v, keep;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {63'b0, ready}, 64'd0);
    chk("R1 clkEn", {63'b0, clkEn}, 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    readBoth(v);
    chk("R1 result after reset", v, 64'd0);

    // R4 signed corner operands
    runOp("R4 min*min", 0, 0, 0, 32'h80000000, 32'h80000000);
    runOp("R4 max*max", 0, 0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    runOp("R4 -1*-1",   0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    runOp("R4 1*min",   0, 0, 0, 32'h00000001, 32'h80000000);
    runOp("R4 min*1",   0, 0, 0, 32'h80000000, 32'h00000001);
    runOp("R4 signed acc", 0, 1, 64'h10000000_12345678, 32'h80000000, 32'h80000000);
    // R3 unsigned, including wrap
    runOp("R3 -1*-1 unsigned", 1, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    runOp("R3 wrap", 1, 1, 64'hFFFFFFFF_FFFFFFFF, 32'd2, 32'd3);
    runOp("R3 acc",  1, 1, 64'h80000000_00000001, 32'd2, 32'd3);
    // R9 bare product after clear
    runOp("R9 plain multiply", 0, 0, 0, 32'h12345678, 32'hFEDCBA90);

    // R5 32-bit accumulate: low word only
    preload({32'hDEADBEEF, 32'h0001FFFE});
    startWait(0, 32'h0000FFFF, 32'h0000FFFF);
    readHigh = 1'b0; #1;
    chk("R5 low word accumulate", {32'b0, result}, {32'b0, 32'h0000FFFF * 32'h0000FFFF + 32'h0001FFFE});
    // R6 half select
    readHigh = 1'b1; #1;
    keep = refMac(0, 32'h0000FFFF, 32'h0000FFFF, {32'hDEADBEEF, 32'h0001FFFE});
    chk("R6 high half", {32'b0, result}, {32'b0, keep[63:32]});
    readHigh = 1'b0; #1;
    chk("R6 low half", {32'b0, result}, {32'b0, keep[31:0]});
    clearUnit();

    // R8 loads ignored while running and while ready
    unsignedMode = 1'b1; busA = 32'd7; busB = 32'd9; loadOps = 1'b1;
    @(negedge clk); loadOps = 1'b0;
    repeat (4) @(negedge clk);
    busA = 32'hFFFFFFFF; busB = 32'hFFFFFFFF; loadOps = 1'b1; loadAcc = 1'b1;
    @(negedge clk); loadOps = 1'b0; loadAcc = 1'b0;
    repeat (30) begin if (!ready) @(negedge clk); end
    readBoth(v);
    chk("R8 load during run ignored", v, 64'd63);
    busA = 32'h5; busB = 32'h5; loadOps = 1'b1; loadAcc = 1'b1;
    @(negedge clk); loadOps = 1'b0; loadAcc = 1'b0;
    @(negedge clk);
    chk("R8 ready kept", {63'b0, ready}, 64'd1);
    readBoth(v);
    chk("R8 load while ready ignored", v, 64'd63);
    clearUnit();

    // R10 simultaneous loads: operand load wins
    preload(64'h00000000_00000100);
    busA = 32'd4; busB = 32'd5; unsignedMode = 1'b1; loadOps = 1'b1; loadAcc = 1'b1;
    @(negedge clk); loadOps = 1'b0; loadAcc = 1'b0;
    repeat (30) begin if (!ready) @(negedge clk); end
    readBoth(v);
    chk("R10 operand load wins", v, 64'h114);
    clearUnit();

    // Random operands, both modes, with and without accumulate
    for (int i = 0; i < 40; i++) begin
      logic uns, pre;
      logic [63:0] acc;
      uns = 1'($urandom);
      pre = 1'($urandom);
      acc = {$urandom, $urandom};
      runOp(uns ? "R3 random" : "R4 random", uns, pre, acc, $urandom, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule